// File: doc/BRIEF.md
# Ready-Gated Control Register Bank with Value Snapshot

This block holds a small set of control registers on a bus clock and hands them to a loop controller that runs on a separate core clock. The controller signals whether it can take configuration. While that signal is low, every bus write is dropped and the register keeps what it held before. The ready signal passes through a two-flop synchronizer into the bus domain before it is used to gate writes.

The controller keeps a live value register that it can rewrite in any core cycle. The bus cannot read that register directly. To read it, software writes 1 to a request bit. The request crosses to the core clock as a toggle through a two-flop synchronizer. The core side captures the live value and answers with a toggle of its own. The bus side then latches the captured word into a readable snapshot register. If the controller is writing the live value in the same core cycle as the capture, the snapshot holds zero.

Top module: `gated_reg_bank`

## Requirements
- R1: After reset, the config register (address 0), the multiplier register (address 1) and the snapshot register (address 2) read 0, and bit 0 of the sync/status register (address 3) reads 0.
- R2: With the synchronized ready flag high, a bus write to address 0 or 1 stores `bus_wdata`, and the stored word reads back on `bus_rdata` at the same address.
- R3: With the synchronized ready flag low, a bus write to any address has no effect, and every register keeps its old contents.
- R4: Bit 1 of the register at address 3 reads the two-flop synchronized copy of `core_ready`.
- R5: A write of 1 to bit 0 at address 3 starts a snapshot. From the cycle after that write, bit 0 reads 1 until the snapshot has landed, and then it returns to 0 by itself.
- R6: When no core update coincides with the capture, the snapshot at address 2 equals the live value the core held when the request arrived.
- R7: When `core_val_we` is high in the core cycle that captures the value, the snapshot reads zero.
- R8: The live value changes only in core cycles with `core_val_we` high, and then it takes `core_val_d`.
- R9: The snapshot register at address 2 is read-only, and bus writes to it do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| core_clk | input | 1 | Core-side clock |
| core_rst | input | 1 | Synchronous active-high reset, core domain |
| core_ready | input | 1 | Core can accept configuration |
| core_val_we | input | 1 | Loop controller updates the live value |
| core_val_d | input | DATA_W | New live value |
| cfg_out | output | DATA_W | Config register toward the core |
| mult_out | output | DATA_W | Multiplier register toward the core |

## Verification
The bench lowers ready and writes both control registers and the snapshot address. A bank that ignored the gate would take the new words and read them back. The bench holds `core_val_we` high across a whole snapshot request. A design that captured the old or new value instead of zero would return a non-zero word. It checks that the request bit is still set in the cycle after the write and clear afterwards. A bridge that never cleared the bit, or cleared it before the word landed, would hang the poll or return a stale snapshot. Snapshots of several values check that the captured word matches what the core last wrote.

// File: rtl/gated_bank_pkg.sv
package gated_bank_pkg;

    localparam int ADDR_W       = 2;
    localparam int SYNC_REQ_BIT = 0;
    localparam int SYNC_RDY_BIT = 1;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CFG  = 2'd0,
        ADR_MULT = 2'd1,
        ADR_LIVE = 2'd2,
        ADR_SYNC = 2'd3
    } reg_addr_e;

    function automatic logic toggle_seen(input logic now_v, input logic prev_v);
        return now_v ^ prev_v;
    endfunction

endpackage

// File: rtl/gb_sync.sv
module gb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gb_core_side.sv
module gb_core_side
    import gated_bank_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_tgl_in,
    input  logic              val_we,
    input  logic [DATA_W-1:0] val_d,
    output logic [DATA_W-1:0] cap_q,
    output logic              ack_tgl
);
    logic              req_s, req_d, req_edge;
    logic [DATA_W-1:0] live_q;

    gb_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk(clk), .rst(rst), .d(req_tgl_in), .q(req_s)
    );

    assign req_edge = toggle_seen(req_s, req_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_d   <= 1'b0;
            live_q  <= '0;
            cap_q   <= '0;
            ack_tgl <= 1'b0;
        end else begin
            req_d <= req_s;
            if (val_we) live_q <= val_d;
            if (req_edge) begin
                cap_q   <= val_we ? '0 : live_q;
                ack_tgl <= ~ack_tgl;
            end
        end
    end

    AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !val_we |=> $stable(live_q)); // R8
    AST_LIVE_LOAD: assert property (@(posedge clk) disable iff (rst)
        val_we |=> live_q == $past(val_d)); // R8
    AST_COLLIDE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_edge && val_we) |=> (cap_q == '0)); // R7
    AST_ACK_ONCE: assert property (@(posedge clk) disable iff (rst)
        !req_edge |=> $stable(ack_tgl)); // R5
endmodule

// File: rtl/gb_bus_regs.sv
module gb_bus_regs
    import gated_bank_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ready_in,
    input  logic              ack_tgl_in,
    input  logic [DATA_W-1:0] cap_in,
    output logic              req_tgl,
    output logic [DATA_W-1:0] cfg_q,
    output logic [DATA_W-1:0] mult_q
);
    reg_addr_e         sel;
    logic              rdy_s, ack_s, ack_d, ack_edge, wr_ok, pend_q;
    logic [DATA_W-1:0] snap_q;

    gb_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rdy_sync (
        .clk(clk), .rst(rst), .d(ready_in), .q(rdy_s)
    );
    gb_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk), .rst(rst), .d(ack_tgl_in), .q(ack_s)
    );

    assign sel      = reg_addr_e'(addr);
    assign wr_ok    = we && rdy_s;
    assign ack_edge = toggle_seen(ack_s, ack_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            mult_q  <= '0;
            snap_q  <= '0;
            pend_q  <= 1'b0;
            req_tgl <= 1'b0;
            ack_d   <= 1'b0;
        end else begin
            ack_d <= ack_s;
            if (wr_ok && sel == ADR_CFG)  cfg_q  <= wdata;
            if (wr_ok && sel == ADR_MULT) mult_q <= wdata;
            if (wr_ok && sel == ADR_SYNC && wdata[SYNC_REQ_BIT] && !pend_q) begin
                req_tgl <= ~req_tgl;
                pend_q  <= 1'b1;
            end else if (ack_edge) begin
                snap_q <= cap_in;
                pend_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            ADR_CFG:  rdata = cfg_q;
            ADR_MULT: rdata = mult_q;
            ADR_LIVE: rdata = snap_q;
            ADR_SYNC: begin
                rdata[SYNC_REQ_BIT] = pend_q;
                rdata[SYNC_RDY_BIT] = rdy_s;
            end
        endcase
    end

    AST_WR_GATED: assert property (@(posedge clk) disable iff (rst)
        !rdy_s |=> ($stable(cfg_q) && $stable(mult_q))); // R3
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !ack_edge) |=> pend_q); // R5
    AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (rst)
        !ack_edge |=> $stable(snap_q)); // R9
    AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (rst)
        pend_q |=> $stable(req_tgl)); // R5
endmodule

// File: rtl/gated_reg_bank.sv
module gated_reg_bank
    import gated_bank_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              core_clk,
    input  logic              core_rst,
    input  logic              core_ready,
    input  logic              core_val_we,
    input  logic [DATA_W-1:0] core_val_d,
    output logic [DATA_W-1:0] cfg_out,
    output logic [DATA_W-1:0] mult_out
);
    logic              req_tgl, ack_tgl;
    logic [DATA_W-1:0] cap_w;

    gb_bus_regs #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_bus (
        .clk(bus_clk), .rst(bus_rst), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .ready_in(core_ready),
        .ack_tgl_in(ack_tgl), .cap_in(cap_w), .req_tgl(req_tgl),
        .cfg_q(cfg_out), .mult_q(mult_out)
    );

    gb_core_side #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_core (
        .clk(core_clk), .rst(core_rst), .req_tgl_in(req_tgl),
        .val_we(core_val_we), .val_d(core_val_d),
        .cap_q(cap_w), .ack_tgl(ack_tgl)
    );
endmodule

// File: tb/tb_gated_reg_bank.sv
module tb_gated_reg_bank;
    localparam int DW = 16;

    typedef struct packed {
        logic          rdy;
        logic [1:0]    addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] exp;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd0, 16'h1234, 16'h1234},  // R2
        '{1'b1, 2'd1, 16'h00A5, 16'h00A5},  // R2
        '{1'b0, 2'd0, 16'hFFFF, 16'h1234},  // R3
        '{1'b0, 2'd1, 16'h0F0F, 16'h00A5},  // R3
        '{1'b1, 2'd2, 16'hBEEF, 16'h0000},  // R9
        '{1'b1, 2'd0, 16'h8001, 16'h8001}   // R2
    };

    logic          bus_clk = 0, core_clk = 0;
    logic          bus_rst = 1, core_rst = 1;
    logic          bus_we = 0;
    logic [1:0]    bus_addr = 0;
    logic [DW-1:0] bus_wdata = 0, bus_rdata;
    logic          core_ready = 0, core_val_we = 0;
    logic [DW-1:0] core_val_d = 0, cfg_out, mult_out;

    int nvec = 0, nbad = 0;
    bit done = 0;

    always #10 bus_clk  = ~bus_clk;
    always #7  core_clk = ~core_clk;

    gated_reg_bank #(.DATA_W(DW)) dut (.*);

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge bus_clk); bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge bus_clk); bus_we = 0;
    endtask

    task automatic bread(input logic [1:0] a, output logic [DW-1:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic set_ready(input logic r);
        @(negedge core_clk); core_ready = r;
        repeat (6) @(negedge bus_clk);
    endtask

    task automatic core_load(input logic [DW-1:0] v);
        @(negedge core_clk); core_val_we = 1; core_val_d = v;
        @(negedge core_clk); core_val_we = 0;
    endtask

    task automatic fetch(output logic [DW-1:0] v);
        logic [DW-1:0] st;
        bwrite(2'd3, 16'h0001);
        bread(2'd3, st);
        check("R5 pending set", {15'd0, st[0]}, 16'd1);
        for (int i = 0; i < 100; i++) begin
            @(negedge bus_clk); bread(2'd3, st);
            if (!st[0]) break;
        end
        check("R5 pending cleared", {15'd0, st[0]}, 16'd0);
        bread(2'd2, v);
    endtask

    initial begin
        repeat (20000) @(posedge bus_clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] r;
        repeat (4) @(negedge bus_clk);
        bus_rst = 0; core_rst = 0;
        @(negedge bus_clk);
        // R1 reset state
        bread(2'd0, r); check("R1 cfg", r, 16'h0);
        bread(2'd1, r); check("R1 mult", r, 16'h0);
        bread(2'd2, r); check("R1 snapshot", r, 16'h0);
        bread(2'd3, r); check("R1 sync", r, 16'h0);

        // vector table: R2 R3 R9
        for (int k = 0; k < NV; k++) begin
            set_ready(VECS[k].rdy);
            bwrite(VECS[k].addr, VECS[k].wdata);
            bread(VECS[k].addr, r);
            check("R2/R3/R9 vector", r, VECS[k].exp);
        end

        // R4 ready status bit
        set_ready(1'b0);
        bread(2'd3, r); check("R4 ready low", {15'd0, r[1]}, 16'd0);
        set_ready(1'b1);
        bread(2'd3, r); check("R4 ready high", {15'd0, r[1]}, 16'd1);
        check("R2 cfg_out port", cfg_out, 16'h8001);
        check("R2 mult_out port", mult_out, 16'h00A5);

        // R6 / R8 snapshots of several values
        core_load(16'hC3A1);
        fetch(r); check("R6 snapshot 1", r, 16'hC3A1);
        core_load(16'h0077);
        repeat (3) @(negedge core_clk);
        fetch(r); check("R6 snapshot 2", r, 16'h0077);
        fetch(r); check("R8 value held", r, 16'h0077);

        // R7 collision: update held high across the capture
        @(negedge core_clk); core_val_we = 1; core_val_d = 16'h5A5A;
        fetch(r); check("R7 collision zero", r, 16'h0000);
        @(negedge core_clk); core_val_we = 0;
        fetch(r); check("R8 value after update", r, 16'h5A5A);

        // R3 request write dropped while not ready
        set_ready(1'b0);
        bwrite(2'd3, 16'h0001);
        bread(2'd3, r); check("R3 request dropped", {15'd0, r[0]}, 16'd0);
        bread(2'd2, r); check("R3 snapshot kept", r, 16'h5A5A);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule